// File: doc/BRIEF.md
# Byte-Rotating Frame Pattern Aligner

The block takes a stream of 32-bit words and aligns it to the frame. The frame phase and the byte phase of that stream are arbitrary, but bit alignment is already done. In each word the byte that arrived first is `din[31:24]`. The block keeps the previous word and joins it to the current one. This lets it look for the framing transition, an A1 byte (0xF6) followed directly by an A2 byte (0x28), at every byte offset in one cycle. The offsets include the pair that crosses from the previous word into the current one.

When the frame state machine enables the search and the transition is found, the block sets a 2-bit byte rotation. The rotation places the first A2 byte at the start of an output word, so the A1-to-A2 change falls on a 32-bit boundary. The rotation is then held until the search is enabled again and finds a new transition. The output is a registered, byte-rotated word. A one-cycle `pattdet` pulse marks the aligned word of four A2 bytes that directly follows an aligned word of four A1 bytes. The in-frame and out-of-frame decision is left to the frame state machine downstream.

Top module: `frame_byte_aligner`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, `pattdet` is 0, the rotation is 0 and the stored previous word is 0.
- R2: A match is 0xF6 followed by 0x28 in consecutive stream bytes, where `din[31:24]` is the earliest byte of a word. The block tests four pairs: the last byte of the previous word with `din[31:24]`, and the three pairs inside the current word.
- R3: If the first 0x28 of a match is byte r of the current word (r=0 for `din[31:24]`, up to r=3 for `din[7:0]`), the rotation becomes r.
- R4: With rotation 0, `dout` equals the `din` of the previous cycle. With rotation r≠0, `dout` is registered from previous-word bytes r..3 followed by current-word bytes 0..r-1, earliest byte in `dout[31:24]`.
- R5: A rotation found in a cycle already applies to the output word registered in that same cycle.
- R6: While `search_en` is low the rotation does not change, even if a match is present.
- R7: When several pairs match in one cycle, the lowest r wins.
- R8: `pattdet` is high for exactly one cycle, registered with `dout`, when the new `dout` is 0x28282828 and the previous `dout` was 0xF6F6F6F6. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Allows the rotation to be updated on a match |
| din | input | 32 | Unaligned word, earliest byte in bits 31:24 |
| dout | output | 32 | Registered, byte-rotated word |
| pattdet | output | 1 | Aligned A1 word followed by aligned A2 word |

## Verification
The bench places a run of eight A1 bytes and four A2 bytes at all four byte phases. It steps through every pair of old and new rotation, which separates the bypass path for the new rotation (R5) from a stale register, and confirms that the `pattdet` cycle moves with the phase. A pattern at a different phase with `search_en` low shows that the rotation is held rather than re-learnt. A word holding F6 28 F6 28 separates lowest-offset priority from any other choice. A reset in the middle of a run, followed by plain filler, shows that a rotation of 0 gives a straight one-cycle delay.

// File: rtl/frame_byte_aligner.sv
module frame_byte_aligner #(
  parameter int BW = 8,
  parameter int NB = 4,
  parameter logic [BW-1:0] A1 = 8'hF6,
  parameter logic [BW-1:0] A2 = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              search_en,
  input  logic [BW*NB-1:0]  din,
  output logic [BW*NB-1:0]  dout,
  output logic              pattdet
);
  localparam int W  = BW * NB;
  localparam int RW = $clog2(NB);

  logic [W-1:0]   prev;
  logic [RW-1:0]  rot, new_rot, eff_rot;
  logic           hit_any;
  logic [2*W-1:0] win, shifted;
  logic [RW:0]    start;
  logic [W-1:0]   aligned;

  assign win = {prev, din};

  always_comb begin
    hit_any = 1'b0;
    new_rot = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (win[2*W-1-BW*(NB-1+i) -: BW] == A1 && win[2*W-1-BW*(NB+i) -: BW] == A2) begin
        hit_any = 1'b1;
        new_rot = RW'(i);
      end
    end
  end

  assign eff_rot = (search_en && hit_any) ? new_rot : rot;
  assign start   = (eff_rot == '0) ? (RW+1)'(NB) : {1'b0, eff_rot};
  assign shifted = win << (BW * start);
  assign aligned = shifted[2*W-1 -: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      rot     <= '0;
      dout    <= '0;
      pattdet <= 1'b0;
    end else begin
      prev    <= din;
      rot     <= eff_rot;
      dout    <= aligned;
      pattdet <= (dout == {NB{A1}}) && (aligned == {NB{A2}});
    end
  end
endmodule

module frame_byte_aligner_chk #(
  parameter int BW = 8,
  parameter int NB = 4,
  parameter logic [BW-1:0] A1 = 8'hF6,
  parameter logic [BW-1:0] A2 = 8'h28
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   search_en,
  input logic [BW*NB-1:0]       din,
  input logic [BW*NB-1:0]       dout,
  input logic                   pattdet,
  input logic [$clog2(NB)-1:0]  rot
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (dout == '0 && !pattdet && rot == '0));

  a_r8_pattdet_content: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pattdet) |-> (dout == {NB{A2}} && $past(dout) == {NB{A1}}));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pattdet |=> !pattdet);

  a_r6_hold_rot: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> $stable(rot));

  a_r4_rot0_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rot) == '0 && !$past(search_en)) |-> dout == $past(din));
endmodule

bind frame_byte_aligner frame_byte_aligner_chk #(.BW(BW), .NB(NB), .A1(A1), .A2(A2)) u_chk (
  .clk(clk), .rst_n(rst_n), .search_en(search_en), .din(din),
  .dout(dout), .pattdet(pattdet), .rot(rot)
);

// File: tb/tb_frame_byte_aligner.sv
module tb_frame_byte_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        search_en = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        pattdet;

  int nvec = 0;
  int nerr = 0;
  int exp_rot = 0;
  logic [31:0] prevw = '0;
  logic [7:0]  st [0:39];

  always #4 clk = ~clk;

  frame_byte_aligner dut (
    .clk(clk), .rst_n(rst_n), .search_en(search_en),
    .din(din), .dout(dout), .pattdet(pattdet)
  );

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  task automatic apply(input logic [31:0] w, input bit en, input int nr, input bit exp_pd, input string req);
    logic [63:0] sh;
    logic [31:0] expd;
    int s;
    search_en = en;
    din = w;
    @(posedge clk);
    #1;
    if (nr >= 0) exp_rot = nr;
    s = (exp_rot == 0) ? 4 : exp_rot;
    sh = {prevw, w} << (8 * s);
    expd = sh[63:32];
    nvec++;
    if (dout !== expd || pattdet !== exp_pd) begin
      nerr++;
      $display("FAIL %s: actual dout=%h pattdet=%b expected dout=%h pattdet=%b", req, dout, pattdet, expd, exp_pd);
    end
    prevw = w;
  endtask

  task automatic trial(input int p, input bit en, input string req);
    int a2, wd, s, pdw;
    bit pd;
    a2 = 16 + p;
    for (int i = 0; i < 40; i++) st[i] = 8'h40 + 8'(i);
    for (int i = a2 - 8; i < a2; i++) st[i] = 8'hF6;
    for (int i = a2; i < a2 + 4; i++) st[i] = 8'h28;
    wd = a2 / 4;
    s = (p == 0) ? 4 : p;
    pdw = (a2 - s) / 4 + 1;
    for (int w = 0; w < 10; w++) begin
      pd = (w == pdw) && (en || exp_rot == p);
      apply({st[4*w], st[4*w+1], st[4*w+2], st[4*w+3]}, en,
            (en && w == wd) ? p : -1, pd, req);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    nvec++;
    if (dout !== 32'h0 || pattdet !== 1'b0) begin
      nerr++;
      $display("FAIL R1: actual dout=%h pattdet=%b expected dout=00000000 pattdet=0", dout, pattdet);
    end
    rst_n = 1'b1;

    // R2 R3 R4 R5: every old rotation followed by every new rotation
    for (int po = 0; po < 4; po++)
      for (int pn = 0; pn < 4; pn++) begin
        trial(po, 1'b1, "R3_R5_old");
        trial(pn, 1'b1, "R2_R4_R8_new");
      end

    // R6: locked at 1, pattern at phase 2 with search disabled
    trial(1, 1'b1, "R6_lock");
    trial(2, 1'b0, "R6_hold");
    trial(2, 1'b1, "R6_resume");

    // R7: F6 28 F6 28 in one word, lowest offset (rotation 1) wins
    trial(3, 1'b1, "R7_setup");
    apply(32'h11223344, 1'b1, -1, 1'b0, "R7");
    apply(32'hF628F628, 1'b1, 1, 1'b0, "R7");
    for (int w = 0; w < 4; w++) apply(32'h50515253 + 32'(w), 1'b1, -1, 1'b0, "R7_after");

    // R1: reset in mid-run returns to rotation 0, plain one-cycle delay
    trial(3, 1'b1, "R1_setup");
    rst_n = 1'b0;
    #1;
    nvec++;
    if (dout !== 32'h0 || pattdet !== 1'b0) begin
      nerr++;
      $display("FAIL R1: actual dout=%h pattdet=%b expected dout=00000000 pattdet=0", dout, pattdet);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    exp_rot = 0;
    prevw = '0;
    for (int w = 0; w < 8; w++) apply(32'h0A1B2C3D + 32'(w * 32'h01010101), 1'b0, -1, 1'b0, "R1_R4_rot0");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule